// File: doc/BRIEF.md
# ECC Error Status and Interrupt Unit

This block sits next to the read path of a memory protected by a single-error-correct, double-error-detect code. The decoder feeds it one-cycle pulses when a read word needed a single-bit correction, when a word held an uncorrectable double-bit error, or when a correction had to be dropped, along with the failing address. The unit keeps sticky status flags, two saturating 4-bit error counters and one error-address register shared by both error classes. It drives a single level interrupt that is gated by a global enable and by per-source masks.

Software reaches all state through a small 32-bit register bus with a combinational read path. A control register holds the ECC enable, the correction enable and two injection requests. The write path of the memory controller reads the injection requests directly: while one is set, stored words are corrupted with one or two flipped bits. The error then shows up through this unit when the word is read back. Writing the interrupt-clear bit acknowledges an event by clearing the flags and counters.

Top module: `ecc_err_csr`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: The control register at offset 0x00 stores only bit 10 (ECC enable), bit 11 (correction enable), bit 13 (single-bit injection) and bit 14 (double-bit injection). All other bits read zero. The four stored bits drive ecc_en_o, corr_en_o, inj_sbe_o and inj_dbe_o combinationally.
- R3: A pulse on sbe_i, dbe_i or drop_i sets the sticky flag at status (0x38) bit 2, bit 3 or bit 4 respectively. sbe_i increments the count at 0x40 and dbe_i increments the count at 0x44.
- R4: Both counters saturate at 15 and never wrap.
- R5: The register at 0x48 takes err_addr_i on any sbe_i or dbe_i pulse and holds it otherwise; drop_i alone does not update it. When sbe_i and dbe_i arrive together, both flags and both counters update and the address is taken once.
- R6: Interrupt register 0x3C holds an enable at bit 0 and active-high masks at bits 1 (single), 2 (double) and 3 (dropped). irq_o = enable AND OR over sources of (flag AND NOT mask).
- R7: Writing 0x3C with bit 4 set clears all three flags and both counters in that cycle. Bits 0 to 3 load from the same write, so clear with enable keeps interrupts on and clear alone leaves them off. Bit 4 reads as zero.
- R8: An error pulse in the same cycle as a clear is recorded: its flag reads 1 and its count reads 1 afterwards.
- R9: Reads of unmapped offsets return zero. Writes to the status, count and address registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 8 | Byte offset of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| sbe_i | input | 1 | Corrected single-bit error pulse |
| dbe_i | input | 1 | Uncorrectable double-bit error pulse |
| drop_i | input | 1 | Dropped-correction pulse |
| err_addr_i | input | 32 | Address of the failing read |
| irq_o | output | 1 | Level interrupt |
| ecc_en_o | output | 1 | ECC enable |
| corr_en_o | output | 1 | Correction enable |
| inj_sbe_o | output | 1 | Single-bit injection request to write path |
| inj_dbe_o | output | 1 | Double-bit injection request to write path |

## Verification
The assertions assume that the error pulses are synchronous to clk_i and that the error address is valid in the same cycle as the pulse. They also assume a clear comes only from a bus write to the interrupt register. The stimulus drives every pulse and bus write for exactly one cycle, changing inputs on the falling edge. Counter saturation, clear colliding with a new error, and simultaneous single- and double-bit pulses are produced on purpose so that the priority and hold properties are exercised rather than left vacuous.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL    = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_STAT    = 8'h38;
  localparam logic [BUS_AW-1:0] OFS_INTR    = 8'h3C;
  localparam logic [BUS_AW-1:0] OFS_SBE_CNT = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_DBE_CNT = 8'h44;
  localparam logic [BUS_AW-1:0] OFS_EADDR   = 8'h48;

  localparam int CTRL_ECC_EN  = 10;
  localparam int CTRL_CORR_EN = 11;
  localparam int CTRL_INJ_SBE = 13;
  localparam int CTRL_INJ_DBE = 14;

  // status bit = STAT_BASE + source index
  localparam int STAT_BASE = 2;

  // interrupt reg: enable, masks at MASK_BASE + source index, clear
  localparam int INTR_EN   = 0;
  localparam int MASK_BASE = 1;
  localparam int INTR_CLR  = 4;

  // source indices
  localparam int SRC_SBE  = 0;
  localparam int SRC_DBE  = 1;
  localparam int SRC_DROP = 2;
  localparam int NUM_SRC  = 3;
  localparam int NUM_CNT  = 2;

  typedef struct packed {
    logic inj_dbe;
    logic inj_sbe;
    logic corr_en;
    logic ecc_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

  a_r8_clear_keeps_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/ecc_err_track.sv
module ecc_err_track
  import ecc_err_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int EAW   = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        ev_i,
  input  logic [EAW-1:0]            eaddr_i,
  input  logic                      clr_i,
  output logic [NUM_SRC-1:0]        flags_o,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt_o,
  output logic [EAW-1:0]            eaddr_o
);
  logic [NUM_SRC-1:0] flags_q;
  logic [EAW-1:0]     eaddr_q;
  logic               capture;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flags_q[g] <= 1'b0;
      else if (ev_i[g]) flags_q[g] <= 1'b1;
      else if (clr_i)   flags_q[g] <= 1'b0;
    end

    a_r3_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[g] |=> flags_q[g]);
  end

  // counters only for single- and double-bit classes
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    ecc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (ev_i[c]),
      .clr_i (clr_i),
      .cnt_o (cnt_o[c])
    );
  end

  assign capture = ev_i[SRC_SBE] | ev_i[SRC_DBE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      eaddr_q <= '0;
    else if (capture) eaddr_q <= eaddr_i;
  end

  assign flags_o = flags_q;
  assign eaddr_o = eaddr_q;

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_i[SRC_SBE] || ev_i[SRC_DBE]) |=> $stable(eaddr_q));

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ev_i == '0) |=> flags_q == '0);
endmodule

// File: rtl/ecc_irq_ctl.sv
module ecc_irq_ctl
  import ecc_err_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_SRC-1:0] flags_i,
  output logic               en_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               clr_o,
  output logic               irq_o
);
  logic               en_q;
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (wr_i) begin
      en_q   <= wdata_i[INTR_EN];
      mask_q <= wdata_i[MASK_BASE +: NUM_SRC];
    end
  end

  assign clr_o  = wr_i & wdata_i[INTR_CLR];
  assign irq_o  = en_q & |(flags_i & ~mask_q);
  assign en_o   = en_q;
  assign mask_o = mask_q;

  a_r6_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);

  a_r7_clear_alone_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[INTR_CLR] && !wdata_i[INTR_EN]) |=> !irq_o);
endmodule

// File: rtl/ecc_err_csr.sv
module ecc_err_csr
  import ecc_err_pkg::*;
#(
  parameter int AW    = BUS_AW,
  parameter int DW    = BUS_DW,
  parameter int CNT_W = 4,
  parameter int EAW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          sbe_i,
  input  logic          dbe_i,
  input  logic          drop_i,
  input  logic [EAW-1:0] err_addr_i,
  output logic          irq_o,
  output logic          ecc_en_o,
  output logic          corr_en_o,
  output logic          inj_sbe_o,
  output logic          inj_dbe_o
);
  ctrl_t                         ctrl_q;
  logic                          wr;
  logic                          wr_ctrl, wr_intr;
  logic [NUM_SRC-1:0]            ev, flags, mask;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [EAW-1:0]                eaddr;
  logic                          irq_en, clr;

  assign wr      = req_i & we_i;
  assign wr_ctrl = wr && addr_i == AW'(OFS_CTRL);
  assign wr_intr = wr && addr_i == AW'(OFS_INTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.ecc_en  <= wdata_i[CTRL_ECC_EN];
      ctrl_q.corr_en <= wdata_i[CTRL_CORR_EN];
      ctrl_q.inj_sbe <= wdata_i[CTRL_INJ_SBE];
      ctrl_q.inj_dbe <= wdata_i[CTRL_INJ_DBE];
    end
  end

  assign ecc_en_o  = ctrl_q.ecc_en;
  assign corr_en_o = ctrl_q.corr_en;
  assign inj_sbe_o = ctrl_q.inj_sbe;
  assign inj_dbe_o = ctrl_q.inj_dbe;

  always_comb begin
    ev           = '0;
    ev[SRC_SBE]  = sbe_i;
    ev[SRC_DBE]  = dbe_i;
    ev[SRC_DROP] = drop_i;
  end

  ecc_irq_ctl #(.DW(DW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_intr),
    .wdata_i(wdata_i),
    .flags_i(flags),
    .en_o   (irq_en),
    .mask_o (mask),
    .clr_o  (clr),
    .irq_o  (irq_o)
  );

  ecc_err_track #(.CNT_W(CNT_W), .EAW(EAW)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .eaddr_i(err_addr_i),
    .clr_i  (clr),
    .flags_o(flags),
    .cnt_o  (cnt),
    .eaddr_o(eaddr)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_CTRL): begin
        rdata_o[CTRL_ECC_EN]  = ctrl_q.ecc_en;
        rdata_o[CTRL_CORR_EN] = ctrl_q.corr_en;
        rdata_o[CTRL_INJ_SBE] = ctrl_q.inj_sbe;
        rdata_o[CTRL_INJ_DBE] = ctrl_q.inj_dbe;
      end
      AW'(OFS_STAT):    rdata_o[STAT_BASE +: NUM_SRC] = flags;
      AW'(OFS_INTR): begin
        rdata_o[INTR_EN]              = irq_en;
        rdata_o[MASK_BASE +: NUM_SRC] = mask;
      end
      AW'(OFS_SBE_CNT): rdata_o[CNT_W-1:0] = cnt[SRC_SBE];
      AW'(OFS_DBE_CNT): rdata_o[CNT_W-1:0] = cnt[SRC_DBE];
      AW'(OFS_EADDR):   rdata_o[EAW-1:0]   = eaddr;
      default:          rdata_o = '0;
    endcase
  end

  a_r2_inj_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> inj_dbe_o == $past(wdata_i[CTRL_INJ_DBE]));
endmodule

// File: tb/tb_ecc_err_csr.sv
`timescale 1ns/1ps
module tb_ecc_err_csr;
  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_ERR = 3'd2, K_IRQ = 3'd3, K_OUT = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  addr;   // K_ERR: pulse bits {drop,dbe,sbe}
    logic [31:0] data;   // K_ERR: error address
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{K_RD,  8'h00, 32'h0,        32'h0,        4'd1},  // R1
    '{K_RD,  8'h3C, 32'h0,        32'h0,        4'd1},
    '{K_IRQ, 8'h00, 32'h0,        32'h0,        4'd1},
    '{K_WR,  8'h00, 32'hFFFFFFFF, 32'h0,        4'd2},  // R2
    '{K_RD,  8'h00, 32'h0,        32'h00006C00, 4'd2},
    '{K_OUT, 8'h00, 32'h0,        32'hF,        4'd2},
    '{K_WR,  8'h00, 32'h00000C00, 32'h0,        4'd2},
    '{K_OUT, 8'h00, 32'h0,        32'h3,        4'd2},
    '{K_ERR, 8'h01, 32'h10000040, 32'h0,        4'd3},  // R3
    '{K_RD,  8'h38, 32'h0,        32'h4,        4'd3},
    '{K_RD,  8'h40, 32'h0,        32'h1,        4'd3},
    '{K_RD,  8'h48, 32'h0,        32'h10000040, 4'd5},  // R5
    '{K_IRQ, 8'h00, 32'h0,        32'h0,        4'd6},  // R6
    '{K_WR,  8'h3C, 32'h1,        32'h0,        4'd6},
    '{K_IRQ, 8'h00, 32'h0,        32'h1,        4'd6},
    '{K_WR,  8'h3C, 32'h3,        32'h0,        4'd6},
    '{K_IRQ, 8'h00, 32'h0,        32'h0,        4'd6},
    '{K_ERR, 8'h02, 32'h20000080, 32'h0,        4'd3},
    '{K_IRQ, 8'h00, 32'h0,        32'h1,        4'd6},
    '{K_RD,  8'h38, 32'h0,        32'hC,        4'd3},
    '{K_RD,  8'h44, 32'h0,        32'h1,        4'd3},
    '{K_RD,  8'h48, 32'h0,        32'h20000080, 4'd5},
    '{K_ERR, 8'h03, 32'h30000000, 32'h0,        4'd5},
    '{K_RD,  8'h40, 32'h0,        32'h2,        4'd5},
    '{K_RD,  8'h44, 32'h0,        32'h2,        4'd5},
    '{K_RD,  8'h48, 32'h0,        32'h30000000, 4'd5},
    '{K_WR,  8'h3C, 32'h11,       32'h0,        4'd7},  // R7
    '{K_RD,  8'h38, 32'h0,        32'h0,        4'd7},
    '{K_RD,  8'h40, 32'h0,        32'h0,        4'd7},
    '{K_RD,  8'h3C, 32'h0,        32'h1,        4'd7},
    '{K_IRQ, 8'h00, 32'h0,        32'h0,        4'd7},
    '{K_ERR, 8'h04, 32'h00000004, 32'h0,        4'd3},
    '{K_RD,  8'h38, 32'h0,        32'h10,       4'd3},
    '{K_IRQ, 8'h00, 32'h0,        32'h1,        4'd6},
    '{K_RD,  8'h48, 32'h0,        32'h30000000, 4'd5},
    '{K_WR,  8'h3C, 32'h10,       32'h0,        4'd7},
    '{K_RD,  8'h3C, 32'h0,        32'h0,        4'd7},
    '{K_IRQ, 8'h00, 32'h0,        32'h0,        4'd7},
    '{K_RD,  8'h38, 32'h0,        32'h0,        4'd7},
    '{K_WR,  8'h40, 32'hF,        32'h0,        4'd9},  // R9
    '{K_RD,  8'h40, 32'h0,        32'h0,        4'd9},
    '{K_WR,  8'h48, 32'h1234,     32'h0,        4'd9},
    '{K_RD,  8'h48, 32'h0,        32'h30000000, 4'd9},
    '{K_WR,  8'h38, 32'h1C,       32'h0,        4'd9},
    '{K_RD,  8'h04, 32'h0,        32'h0,        4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, err_addr_i = '0;
  logic        sbe_i = 1'b0, dbe_i = 1'b0, drop_i = 1'b0;
  logic        irq_o, ecc_en_o, corr_en_o, inj_sbe_o, inj_dbe_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_csr dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sbe_i(sbe_i), .dbe_i(dbe_i),
    .drop_i(drop_i), .err_addr_i(err_addr_i), .irq_o(irq_o), .ecc_en_o(ecc_en_o),
    .corr_en_o(corr_en_o), .inj_sbe_o(inj_sbe_o), .inj_dbe_o(inj_dbe_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [2:0] m, input logic [31:0] ea);
    @(negedge clk);
    sbe_i = m[0]; dbe_i = m[1]; drop_i = m[2]; err_addr_i = ea;
    @(negedge clk);
    sbe_i = 1'b0; dbe_i = 1'b0; drop_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].kind)
        K_WR:  bus_wr(VEC[i].addr, VEC[i].data);
        K_RD: begin bus_rd(VEC[i].addr, d); check(tag, d, VEC[i].exp); end
        K_ERR: pulse(VEC[i].addr[2:0], VEC[i].data);
        K_IRQ: begin @(negedge clk); #1 check(tag, {31'b0, irq_o}, VEC[i].exp); end
        K_OUT: begin
          @(negedge clk);
          #1 check(tag, {28'b0, inj_dbe_o, inj_sbe_o, corr_en_o, ecc_en_o}, VEC[i].exp);
        end
        default: ;
      endcase
    end

    // R4: 17 single-bit pulses saturate at 15
    for (int k = 0; k < 17; k++) pulse(3'b001, 32'hA0 + k);
    bus_rd(8'h40, d); check("R4 sbe count saturates", d, 32'd15);
    for (int k = 0; k < 16; k++) pulse(3'b010, 32'hB0);
    bus_rd(8'h44, d); check("R4 dbe count saturates", d, 32'd15);
    bus_rd(8'h48, d); check("R5 last address kept", d, 32'hB0);

    // R8: clear and single-bit error in the same cycle
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h3C; wdata_i = 32'h10; sbe_i = 1'b1; err_addr_i = 32'hC0;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; sbe_i = 1'b0;
    bus_rd(8'h38, d); check("R8 flag kept on clear", d, 32'h4);
    bus_rd(8'h40, d); check("R8 count is one", d, 32'd1);
    bus_rd(8'h44, d); check("R8 dbe count cleared", d, 32'd0);

    // R1: reset mid-run
    bus_wr(8'h00, 32'h00006C00);
    bus_wr(8'h3C, 32'h1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    bus_rd(8'h00, d); check("R1 ctrl after reset", d, 32'h0);
    bus_rd(8'h48, d); check("R1 addr after reset", d, 32'h0);
    bus_rd(8'h38, d); check("R1 status after reset", d, 32'h0);
    #1 check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule